// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. Software controls it through a small byte-wide register port. It holds a control byte and a 16-bit result pair. The analog comparator and the trial DAC sit outside the block. The block drives the trial code on `dac_code` and reads the comparator's answer on `cmp_hi`. A divided conversion clock reaches the block as a one-cycle enable pulse, `conv_en`. All conversion timing is counted in those pulses.

Software starts a conversion by setting the go bit. The hold switch then opens, and the block waits for the first conversion period. It then decides one result bit per period, from the most significant bit down. When it finishes, it updates the result pair, drops go and raises the interrupt flag, all in one edge. Clearing go early abandons the conversion. The old result is kept and a short settling hold follows. While the converter is switched off, the two result bytes serve as ordinary scratch registers.

The register port is a plain single-cycle write strobe with registered read-back outputs. It has no valid/ready handshake and never applies back-pressure: every write is taken on the edge where `wr_en` is high.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, `ctrl_q` reads 0, `res_q` reads 0, `irq` is low and `sample_on` is high.
- R2: Register map for `wr_sel` and `ctrl_q`:
  - Select 0 is control. Bit 0 is enable, bit 1 is go, bit 2 is the format (1 = right-justified) and bit 3 is the interrupt flag.
  - Select 1 is the high result byte and select 2 is the low result byte.
  - `res_q` is {high, low}.
  - An accepted conversion completes on the 11th `conv_en` pulse after the go write.
- R3: Each period tests one trial bit, from bit 9 down to bit 0. The bit is kept when `cmp_hi` is 1 and cleared otherwise. With `cmp_hi` = (input >= `dac_code`), the result equals the 10-bit input.
- R4: `sample_on` is low from the edge that accepts go until the conversion completes or is aborted.
- R5: On the completing edge, `res_q` loads the result, go reads 0 and `irq` rises, all together.
- R6: `irq` stays high until software writes the control byte with bit 3 at 0.
- R7: Writing go = 0 (or enable = 0) during a conversion stops it. `res_q` keeps its previous value and `irq` does not rise.
- R8: After an abort, go writes are ignored until 2 `conv_en` pulses have passed.
- R9: A go write during a running conversion neither restarts nor lengthens it.
- R10: With format 1, the result sits in `res_q[9:0]` with zeros above. With format 0, it sits in `res_q[15:6]` with zeros below.
- R11: While enable is 0, writes to select 1 and select 2 load the bytes. While enable is 1, such writes are ignored.
- R12: A control write that sets enable and go together, while enable was 0, starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | One-cycle pulse per conversion-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 control, 1 high byte, 2 low byte) |
| wr_data | input | 8 | Write data |
| cmp_hi | input | 1 | Comparator decision: input at or above trial code |
| ctrl_q | output | 8 | Control byte read-back |
| res_q | output | 16 | Result pair {high, low} |
| dac_code | output | 10 | Trial code for the external DAC |
| sample_on | output | 1 | Hold switch connected to the input |
| irq | output | 1 | Conversion-complete interrupt flag |

## Verification
The bench converts all-ones, all-zeros and mixed inputs in both formats. It compares each result pair against a queue of expected values and counts the periods each conversion takes. A sequencer that started deciding on the go edge would finish in 10 periods, and a wrong keep/clear rule would show up as wrong mixed codes. The bench aborts a conversion and then writes go inside the hold. It would catch a design that wrote a partial result, raised the interrupt, or accepted go after only one period. It also writes go again mid-conversion, sets enable and go together, and writes the result bytes while enabled. A restart would lengthen the count, and the other two mistakes would show up as spurious starts or overwritten bytes.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_STEP = 2'd2,
    ST_HOLD = 2'd3
  } sar_state_e;

  localparam int CTL_ON  = 0;
  localparam int CTL_GO  = 1;
  localparam int CTL_FMT = 2;
  localparam int CTL_IRQ = 3;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_LO   = 2'd2;
endpackage

// File: rtl/sar_justify.sv
module sar_justify #(
  parameter int RES_W  = 10,
  parameter int PAIR_W = 16
) (
  input  logic [RES_W-1:0]  res,
  input  logic              right_fmt,
  output logic [PAIR_W-1:0] pair
);
  localparam int PAD_W = PAIR_W - RES_W;

  logic [PAIR_W-1:0] right_v;
  logic [PAIR_W-1:0] left_v;

  generate
    if (PAD_W > 0) begin : g_pad
      assign right_v = {{PAD_W{1'b0}}, res};
      assign left_v  = {res, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign right_v = res;
      assign left_v  = res;
    end
  endgenerate

  assign pair = right_fmt ? right_v : left_v;
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_fire,
  input  logic             step_fire,
  input  logic             cmp_hi,
  output logic [RES_W-1:0] code,
  output logic [RES_W-1:0] decided,
  output logic             last_bit
);
  localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] mask;

  // Keep the trial bit when the input is at or above the trial code.
  assign decided  = cmp_hi ? code : (code & ~mask);
  assign last_bit = mask[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      mask <= '0;
    end else if (arm_fire) begin
      code <= MSB_ONLY;
      mask <= MSB_ONLY;
    end else if (step_fire) begin
      if (mask[0]) begin
        code <= decided;
        mask <= '0;
      end else begin
        code <= decided | (mask >> 1);
        mask <= mask >> 1;
      end
    end
  end
endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
  import sar_pkg::*;
#(
  parameter int HOLD_PERIODS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_en,
  input  logic       start_req,
  input  logic       abort_req,
  input  logic       last_bit,
  output sar_state_e state,
  output logic       arm_fire,
  output logic       step_fire,
  output logic       done
);
  localparam int HC_W = (HOLD_PERIODS > 1) ? $clog2(HOLD_PERIODS) : 1;
  localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(HOLD_PERIODS - 1);

  logic [HC_W-1:0] hold_cnt;

  assign arm_fire  = (state == ST_ARM)  && conv_en && !abort_req;
  assign step_fire = (state == ST_STEP) && conv_en && !abort_req;
  assign done      = step_fire && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      hold_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_req) state <= ST_ARM;
        ST_ARM: begin
          if (abort_req) begin
            state    <= ST_HOLD;
            hold_cnt <= '0;
          end else if (conv_en) begin
            state <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (abort_req) begin
            state    <= ST_HOLD;
            hold_cnt <= '0;
          end else if (done) begin
            state <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (conv_en) begin
            if (hold_cnt == HOLD_LAST) state <= ST_IDLE;
            else hold_cnt <= hold_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_pkg::*;
#(
  parameter int RES_W        = 10,
  parameter int BYTE_W       = 8,
  parameter int HOLD_PERIODS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_en,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                cmp_hi,
  output logic [BYTE_W-1:0]   ctrl_q,
  output logic [2*BYTE_W-1:0] res_q,
  output logic [RES_W-1:0]    dac_code,
  output logic                sample_on,
  output logic                irq
);
  localparam int PAIR_W = 2 * BYTE_W;

  sar_state_e        state;
  logic              on_q, fmt_q, irq_q, go_w;
  logic              ctrl_wr, start_req, abort_req;
  logic              arm_fire, step_fire, done_w, last_bit;
  logic [RES_W-1:0]  decided;
  logic [PAIR_W-1:0] pair_new, pair_q;

  assign go_w    = (state == ST_ARM) || (state == ST_STEP);
  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

  // Go is honoured only when enable was already set and the sequencer is idle.
  assign start_req = ctrl_wr && wr_data[CTL_GO] && wr_data[CTL_ON] && on_q
                     && (state == ST_IDLE);
  assign abort_req = ctrl_wr && go_w && (!wr_data[CTL_GO] || !wr_data[CTL_ON]);

  sar_fsm #(.HOLD_PERIODS(HOLD_PERIODS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en),
    .start_req(start_req), .abort_req(abort_req), .last_bit(last_bit),
    .state(state), .arm_fire(arm_fire), .step_fire(step_fire), .done(done_w)
  );

  sar_core #(.RES_W(RES_W)) u_core (
    .clk(clk), .rst_n(rst_n), .arm_fire(arm_fire), .step_fire(step_fire),
    .cmp_hi(cmp_hi), .code(dac_code), .decided(decided), .last_bit(last_bit)
  );

  sar_justify #(.RES_W(RES_W), .PAIR_W(PAIR_W)) u_just (
    .res(decided), .right_fmt(fmt_q), .pair(pair_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      fmt_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        on_q  <= wr_data[CTL_ON];
        fmt_q <= wr_data[CTL_FMT];
      end
      if (done_w) irq_q <= 1'b1;
      else if (ctrl_wr) irq_q <= wr_data[CTL_IRQ];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
    end else if (done_w) begin
      pair_q <= pair_new;
    end else if (wr_en && !on_q) begin
      if (wr_sel == SEL_HI) pair_q[PAIR_W-1:BYTE_W] <= wr_data;
      else if (wr_sel == SEL_LO) pair_q[BYTE_W-1:0] <= wr_data;
    end
  end

  always_comb begin
    ctrl_q          = '0;
    ctrl_q[CTL_ON]  = on_q;
    ctrl_q[CTL_GO]  = go_w;
    ctrl_q[CTL_FMT] = fmt_q;
    ctrl_q[CTL_IRQ] = irq_q;
  end

  assign res_q     = pair_q;
  assign irq       = irq_q;
  assign sample_on = !go_w;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [7:0]  ctrl_q,
  input logic [15:0] res_q,
  input logic        sample_on,
  input logic        irq,
  input logic        done
);
  // R5
  complete_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> (!ctrl_q[1] && sample_on && irq));

  // R7
  abort_keeps_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_q[1]) && !$past(done)) |-> $stable(res_q));

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && wr_sel == 2'd0)) |=> irq);

  // R11
  pair_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !done) |=> $stable(res_q));

  // R12
  go_needs_prior_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[1]) |-> $past(ctrl_q[0]));
endmodule

bind sar_seq_top sar_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .ctrl_q(ctrl_q), .res_q(res_q), .sample_on(sample_on), .irq(irq),
  .done(done_w)
);

// File: tb/sim_sar_seq_top.sv
module sim_sar_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        cmp_hi;
  logic [9:0]  vin = 10'd0;
  wire  [7:0]  ctrl_q;
  wire  [15:0] res_q;
  wire  [9:0]  dac_code;
  wire         sample_on, irq;

  int n_chk = 0;
  int n_fail = 0;
  int div = 0;
  logic [15:0] exp_q[$];
  logic irq_d = 1'b0;

  always #5 clk = ~clk;

  assign cmp_hi = (vin >= dac_code);

  sar_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .cmp_hi(cmp_hi), .ctrl_q(ctrl_q),
    .res_q(res_q), .dac_code(dac_code), .sample_on(sample_on), .irq(irq)
  );

  always @(negedge clk) begin
    div     <= (div == 3) ? 0 : div + 1;
    conv_en <= (div == 3) && rst_n;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    wr_sel  = sel;
    wr_data = data;
    wr_en   = 1'b1;
    tick();
    wr_en   = 1'b0;
  endtask

  task automatic wait_pulse();
    while (!conv_en) tick();
    tick();
  endtask

  // Driver: push the expected pair, start, count periods until completion.
  task automatic convert(input logic [9:0] v, input logic fmt, input logic poke);
    int periods;
    logic poked;
    logic [7:0] go_byte;
    go_byte = {5'b0, fmt, 2'b11};
    vin = v;
    exp_q.push_back(fmt ? {6'b0, v} : {v, 6'b0});
    wr(2'd0, go_byte);
    check("R4 switch open after go", sample_on, 1'b0);
    check("R8 go accepted", ctrl_q[1], 1'b1);
    periods = 0;
    poked = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (irq) break;
      if (conv_en) periods++;
      if (poke && periods == 5 && !poked) begin
        wr_sel = 2'd0; wr_data = go_byte; wr_en = 1'b1; poked = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      tick();
    end
    wr_en = 1'b0;
    check(poke ? "R9 period count with extra go" : "R2 period count", periods, 11);
    repeat (10) tick();
    check("R6 irq held", irq, 1'b1);
  endtask

  // Monitor: on each completion pop the expected pair and compare.
  always @(negedge clk) begin
    #2;
    if (rst_n && irq && !irq_d) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R7 unexpected completion actual=%0h expected=none", res_q);
      end else begin
        check("R3/R10 result pair", res_q, exp_q.pop_front());
        check("R5 go cleared at completion", ctrl_q[1], 1'b0);
        check("R4 switch closed at completion", sample_on, 1'b1);
      end
    end
    irq_d = irq;
  end

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [15:0] saved;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 ctrl", ctrl_q, 8'h00);
    check("R1 pair", res_q, 16'h0000);
    check("R1 irq", irq, 1'b0);
    check("R1 switch", sample_on, 1'b1);

    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h3C);
    check("R11 bytes writable when off", res_q, 16'hA53C);

    wr(2'd0, 8'b0000_0011);
    check("R12 go with enable ignored", ctrl_q[1], 1'b0);
    check("R12 switch stays closed", sample_on, 1'b1);
    repeat (50) tick();
    check("R12 no completion", irq, 1'b0);

    wr(2'd0, 8'b0000_0101);
    wr(2'd1, 8'h12);
    check("R11 bytes locked when on", res_q, 16'hA53C);

    convert(10'h3FF, 1'b1, 1'b0);
    convert(10'h000, 1'b1, 1'b0);
    convert(10'h2A5, 1'b0, 1'b0);
    convert(10'h155, 1'b1, 1'b1);
    convert(10'h200, 1'b0, 1'b0);

    saved = res_q;
    vin = 10'h0F0;
    wr(2'd0, 8'b0000_0011);
    repeat (9) tick();
    wr(2'd0, 8'b0000_0001);
    check("R7 go dropped on abort", ctrl_q[1], 1'b0);
    check("R4 switch closed on abort", sample_on, 1'b1);
    wait_pulse();
    wr(2'd0, 8'b0000_0011);
    check("R8 go ignored during hold", ctrl_q[1], 1'b0);
    wait_pulse();
    repeat (2) tick();
    check("R7 pair kept", res_q, saved);
    check("R7 no irq", irq, 1'b0);
    convert(10'h0F0, 1'b1, 1'b0);

    wr(2'd0, 8'b0000_0101);
    check("R6 irq cleared by write", irq, 1'b0);

    wr(2'd0, 8'b0000_0000);
    wr(2'd2, 8'h77);
    check("R11 low byte writable after disable", res_q[7:0], 8'h77);

    repeat (5) tick();
    check("R7 no stray completions left", exp_q.size(), 0);
    report();
  end
endmodule